// File: doc/BRIEF.md
# Fuse Row Read Unit with Column Permissions

This block performs row reads from a one-time-programmable fuse array on behalf of software. Software writes a read-address word that names a logical array and a row. The block translates the logical array to a physical one and fetches the 32-bit row through a single-cycle row-read port. It then filters the row through a fixed permission mask chosen by array and row. The filtered value is placed in a data register that the bus can only read.

Every read leaves a done flag or an error flag in a small status word. Rows with no permitted columns are refused. A refused read leaves zero in the data register and raises the error flag. Writes from the bus are ignored while the surrounding register block is write-locked. The fuse storage is shared with other logic, so it lies outside the block. It is reached only through the row-read port.

Top module: `fuse_row_reader`

## Requirements
- R1: In a read-address word, bits [12:11] hold the logical array and bits [10:5] hold the row. Bits [4:0] do not affect the result.
- R2: Logical array 2 reads physical array 1, and logical array 3 reads physical array 2. For both, the full 32-bit row is returned without masking.
- R3: A read of logical array 1 is refused.
- R4: In logical array 0 (physical array 0), the permitted columns are as follows. Row 0 permits columns 28..31 (mask 0xF0000000). Rows 8..15 and row 20 permit every column. Row 16 permits columns 0..7 and 10..16 (mask 0x0001FCFF). Row 17 permits columns 0..2 (mask 0x00000007).
- R5: In logical array 0, row 21 permits columns 0..23 and 29..31 (mask 0xE0FFFFFF). Rows 22, 23 and 40..63 permit every column.
- R6: Any other row of logical array 0 is refused.
- R7: A permitted read loads the data register with the row value ANDed with its mask. It sets status bit 2 (done) and clears status bit 3 (error).
- R8: A refused read loads zero into the data register. It sets status bit 3 (error) and clears status bit 2 (done).
- R9: The data register and the status word show the result of a read-address write from the first clock edge that samples that write. A read-address write in every cycle yields a new result in every cycle.
- R10: A bus write to the data register's offset changes neither the data register nor the status word.
- R11: A read-address write made while the write-lock input is high is ignored. The data register and the status word keep their values.
- R12: After reset the data register is zero and the status word is zero. Status bits other than 2 and 3 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | ADDR_W | Bus byte offset of the write |
| bus_wdata_i | input | 32 | Bus write data |
| wr_lock_i | input | 1 | Register block write-lock state |
| fuse_rd_o | output | 1 | Row-read request to the fuse storage |
| fuse_array_o | output | 2 | Physical array for the row read |
| fuse_row_o | output | 6 | Row for the row read |
| fuse_data_i | input | 32 | Row value returned in the same cycle |
| rd_data_o | output | 32 | Read data register |
| status_o | output | 5 | Status word: bit 3 error, bit 2 done |

## Verification
The bench reads rows at the edges of each permitted span, including rows 0, 15, 16, 17, 21, 23, 40 and 63. It also reads the denied gaps around them, such as rows 1, 7, 18, 19, 24 and 39. An off-by-one in the mask table would therefore show up either as leaked bits or as a false refusal.

Logical arrays 2 and 3 are read against a fuse model that returns a different value for each physical array. A missing or wrong remap would return the wrong row contents. Array 1 is also read; a design that let it through would report done instead of error.

Back-to-back reads, reads with junk in the low address bits, and locked writes are all checked. Writes to the data offset are checked the same way. A design that added a cycle of delay, decoded the reserved bits, or let a blocked write through would disturb the register that should have stayed fixed.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
  localparam int DATA_W    = 32;
  localparam int ARR_W     = 2;
  localparam int ROW_W     = 6;
  localparam int ROW_LSB   = 5;
  localparam int ARR_LSB   = ROW_LSB + ROW_W;
  localparam int ROWS      = 1 << ROW_W;
  localparam int STATUS_W  = 5;
  localparam int DONE_BIT  = 2;
  localparam int ERR_BIT   = 3;

  typedef logic [DATA_W-1:0] word_t;

  // contiguous column span [lo..hi]
  function automatic word_t col_span(int unsigned lo, int unsigned hi);
    logic [2*DATA_W-1:0] t;
    t = ((64'd1 << (hi - lo + 1)) - 64'd1) << lo;
    return t[DATA_W-1:0];
  endfunction

  // permission mask for a row of logical array 0; zero means refused
  function automatic word_t row_mask(int unsigned row);
    word_t m;
    m = '0;
    if (row == 0)                     m = col_span(28, 31);
    else if (row >= 8 && row <= 15)   m = '1;
    else if (row == 16)               m = col_span(0, 7) | col_span(10, 16);
    else if (row == 17)               m = col_span(0, 2);
    else if (row == 20)               m = '1;
    else if (row == 21)               m = col_span(0, 23) | col_span(29, 31);
    else if (row == 22 || row == 23)  m = '1;
    else if (row >= 40 && row <= 63)  m = '1;
    return m;
  endfunction
endpackage

// File: rtl/fuse_rd_mask_table.sv
module fuse_rd_mask_table
  import fuse_rd_pkg::*;
(
  input  logic [ROW_W-1:0] row_i,
  output word_t            mask_o
);
  word_t mask_tab [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign mask_tab[r] = row_mask(r);
  end

  assign mask_o = mask_tab[row_i];
endmodule

// File: rtl/fuse_rd_decode.sv
module fuse_rd_decode
  import fuse_rd_pkg::*;
(
  input  word_t            addr_word_i,
  output logic             grant_o,
  output logic [ARR_W-1:0] phys_arr_o,
  output logic [ROW_W-1:0] row_o,
  output word_t            mask_o
);
  logic [ARR_W-1:0] log_arr;
  word_t            arr0_mask;
  logic             unused_addr;

  assign log_arr = addr_word_i[ARR_LSB +: ARR_W];
  assign row_o   = addr_word_i[ROW_LSB +: ROW_W];
  assign unused_addr = ^{addr_word_i[DATA_W-1:ARR_LSB+ARR_W], addr_word_i[ROW_LSB-1:0]};

  fuse_rd_mask_table u_mask (
    .row_i  (row_o),
    .mask_o (arr0_mask)
  );

  always_comb begin
    grant_o    = 1'b0;
    phys_arr_o = '0;
    mask_o     = '0;
    unique case (log_arr)
      2'd0: begin
        grant_o = |arr0_mask;
        mask_o  = arr0_mask;
      end
      2'd2, 2'd3: begin
        // helper-data arrays: skip physical array slot
        grant_o    = 1'b1;
        phys_arr_o = log_arr - 2'd1;
        mask_o     = '1;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (grant_o) a_r6_grant_has_mask: assert (mask_o != '0);
    if (log_arr == 2'd1) a_r3_arr1_refused: assert (!grant_o);
  end
endmodule

// File: rtl/fuse_rd_result.sv
module fuse_rd_result
  import fuse_rd_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                grant_i,
  input  word_t               mask_i,
  input  word_t               row_data_i,
  output word_t               data_o,
  output logic [STATUS_W-1:0] status_o
);
  word_t data_q;
  logic  done_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (load_i) begin
      data_q <= grant_i ? (row_data_i & mask_i) : '0;
      done_q <= grant_i;
      err_q  <= !grant_i;
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[DONE_BIT] = done_q;
    status_o[ERR_BIT]  = err_q;
  end
  assign data_o = data_q;

  a_r8_refused_is_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (data_q == '0));
  a_r7_done_err_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_q && err_q));
  a_r9_load_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (done_q ^ err_q));
endmodule

// File: rtl/fuse_row_reader.sv
module fuse_row_reader
  import fuse_rd_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] RDADDR_OFS = 8'h00,
  parameter logic [ADDR_W-1:0] RDDATA_OFS = 8'h04
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  input  logic                wr_lock_i,
  output logic                fuse_rd_o,
  output logic [ARR_W-1:0]    fuse_array_o,
  output logic [ROW_W-1:0]    fuse_row_o,
  input  logic [DATA_W-1:0]   fuse_data_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic [STATUS_W-1:0] status_o
);
  logic  accept;
  logic  grant;
  word_t mask;

  // data register offset is read-only: no write path exists
  assign accept = bus_we_i && !wr_lock_i && (bus_addr_i == RDADDR_OFS);

  fuse_rd_decode u_dec (
    .addr_word_i (bus_wdata_i),
    .grant_o     (grant),
    .phys_arr_o  (fuse_array_o),
    .row_o       (fuse_row_o),
    .mask_o      (mask)
  );

  assign fuse_rd_o = accept && grant;

  fuse_rd_result u_res (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .grant_i    (grant),
    .mask_i     (mask),
    .row_data_i (fuse_data_i),
    .data_o     (rd_data_o),
    .status_o   (status_o)
  );

  a_r11_lock_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && wr_lock_i) |=> ($stable(rd_data_o) && $stable(status_o)));
  a_r10_data_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == RDDATA_OFS) |=> ($stable(rd_data_o) && $stable(status_o)));
  a_r3_arr1_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && bus_wdata_i[ARR_LSB +: ARR_W] == 2'd1) |=> status_o[ERR_BIT]);
  a_r12_spare_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & ~((1 << DONE_BIT) | (1 << ERR_BIT))) == '0);
endmodule

// File: tb/fuse_row_reader_tb_top.sv
`timescale 1ns/1ps
module fuse_row_reader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        lock = 1'b0;
  logic        f_rd;
  logic [1:0]  f_arr;
  logic [5:0]  f_row;
  logic [31:0] f_data;
  logic [31:0] rdata;
  logic [4:0]  status;

  int checks = 0;
  int fails  = 0;
  bit drv_issue = 1'b0;

  typedef struct {
    logic [31:0] data;
    logic [4:0]  st;
    string       req;
  } exp_t;
  exp_t exp_q[$];
  exp_t last_exp;

  always #2.5 clk = ~clk;

  fuse_row_reader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .wr_lock_i(lock), .fuse_rd_o(f_rd),
    .fuse_array_o(f_arr), .fuse_row_o(f_row), .fuse_data_i(f_data),
    .rd_data_o(rdata), .status_o(status)
  );

  function automatic logic [31:0] fmodel(logic [1:0] a, logic [5:0] r);
    return 32'h9E37_79B1 * ({24'd0, a, r} + 32'd1);
  endfunction

  assign f_data = fmodel(f_arr, f_row);

  function automatic logic [31:0] exp_mask(int r);
    if (r == 0) return 32'hF000_0000;
    if (r >= 8 && r <= 15) return 32'hFFFF_FFFF;
    if (r == 16) return 32'h0001_FCFF;
    if (r == 17) return 32'h0000_0007;
    if (r == 20 || r == 22 || r == 23) return 32'hFFFF_FFFF;
    if (r == 21) return 32'hE0FF_FFFF;
    if (r >= 40 && r <= 63) return 32'hFFFF_FFFF;
    return 32'h0;
  endfunction

  function automatic exp_t predict(int a, int r, string req);
    exp_t e;
    e.req = req;
    if (a == 0 && exp_mask(r) != 0) begin
      e.data = fmodel(2'd0, r[5:0]) & exp_mask(r);
      e.st   = 5'b00100;
    end else if (a == 2 || a == 3) begin
      e.data = fmodel(2'(a - 1), r[5:0]);
      e.st   = 5'b00100;
    end else begin
      e.data = 32'h0;
      e.st   = 5'b01000;
    end
    return e;
  endfunction

  task automatic issue(logic [7:0] ad, logic [31:0] wd, logic lk, exp_t e);
    @(negedge clk);
    we = 1'b1; addr = ad; wdata = wd; lock = lk;
    drv_issue = 1'b1;
    exp_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    we = 1'b0; lock = 1'b0; drv_issue = 1'b0;
  endtask

  task automatic rd(int a, int r, logic [4:0] lowb, string req);
    exp_t e;
    e = predict(a, r, req);
    issue(8'h00, {19'd0, a[1:0], r[5:0], lowb}, 1'b0, e);
    last_exp = e;
  endtask

  // monitor: pops and compares one edge after each issued item
  initial begin
    bit iss;
    exp_t e;
    forever begin
      @(posedge clk);
      iss = drv_issue;
      @(negedge clk);
      if (iss && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        checks++;
        if (rdata !== e.data || status !== e.st) begin
          fails++;
          $display("FAIL %s: data=%h status=%b expected data=%h status=%b",
                   e.req, rdata, status, e.data, e.st);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    exp_t e;
    last_exp.data = '0; last_exp.st = '0; last_exp.req = "";
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rdata !== 32'h0 || status !== 5'h0) begin
      fails++;
      $display("FAIL R12 reset: data=%h status=%b expected data=0 status=0", rdata, status);
    end

    rd(0, 0,  5'd0, "R4 row0");
    rd(0, 8,  5'd0, "R4 row8");
    rd(0, 15, 5'd0, "R4 row15");
    rd(0, 16, 5'd0, "R4 row16");
    rd(0, 17, 5'd0, "R4 row17");
    rd(0, 20, 5'd0, "R4 row20");
    idle();
    rd(0, 21, 5'd0, "R5 row21");
    rd(0, 22, 5'd0, "R5 row22");
    rd(0, 23, 5'd0, "R5 row23");
    rd(0, 40, 5'd0, "R5 row40");
    rd(0, 63, 5'd0, "R5 row63 R9 back-to-back");
    idle();
    rd(0, 1,  5'd0, "R6 R8 row1");
    rd(0, 7,  5'd0, "R6 R8 row7");
    rd(0, 18, 5'd0, "R6 R8 row18");
    rd(0, 19, 5'd0, "R6 R8 row19");
    rd(0, 24, 5'd0, "R6 R8 row24");
    rd(0, 39, 5'd0, "R6 R8 row39");
    idle();
    rd(2, 5,  5'd0, "R2 arr2 row5");
    rd(3, 63, 5'd0, "R2 arr3 row63");
    rd(2, 0,  5'd0, "R2 arr2 row0");
    rd(1, 8,  5'd0, "R3 arr1 row8");
    rd(0, 16, 5'h1F, "R1 low bits row16");
    rd(0, 21, 5'h0A, "R1 R7 low bits row21");
    idle();
    // R11: locked write must leave previous result
    e = last_exp; e.req = "R11 locked write";
    issue(8'h00, {19'd0, 2'd0, 6'd20, 5'd0}, 1'b1, e);
    rd(0, 2, 5'd0, "R8 refused after lock");
    // R10: write to data offset is ignored
    e = last_exp; e.req = "R10 data offset write";
    issue(8'h04, 32'hDEAD_BEEF, 1'b0, e);
    e = last_exp; e.req = "R10 data offset write 2";
    issue(8'h04, 32'h0000_0000, 1'b0, e);
    rd(0, 12, 5'd0, "R7 R9 row12");
    idle();
    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule